// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor core and offers it at most one pending interrupt at a time on a single level output. Source controllers deliver requests carrying a source number and a priority; each request is answered with an accept or a reject pulse. A lower priority value is more favoured, and 0xFF means masked. When a better request arrives, or the core narrows its priority window, the source already held is sent back to its controller on a bounce port so it can be offered again later. Software can also post an inter-processor interrupt (IPI) by writing an IPI priority. It competes with external sources under the same rule and is presented as source number 2.

The core drives the block through a one-cycle operation port. It can write the current processor priority, write the IPI priority, accept the pending interrupt (read and clear), or signal end of interrupt (EOI). The combined return word is always visible on `cpu_rdata`. Bits 31:24 hold the current processor priority, and bits 23:0 hold the pending source number, where zero means nothing is pending. An accept returns the value shown in the cycle the operation is issued. All results appear on registered outputs in the cycle after the operation or delivery is taken.

Top module: `irq_present_ctl`

## Requirements
- R1: After reset the return word is 0, the output is low, the pending priority is 0xFF and the IPI priority is 0xFF. An accept issued straight after reset therefore yields a return word of 0xFF000000, and the first resend installs no IPI.
- R2: A delivery is rejected (`req_nak`) when its priority is greater than or equal to the current processor priority, or when a source is pending whose pending priority is less than or equal to the delivery's priority.
- R3: Any other delivery is accepted (`req_ack`). Its source number and priority are latched, the output goes high, and a displaced external source is bounced with its number. The output is high exactly when the pending source number is non-zero.
- R4: Writing the IPI priority (op code 1, value in bits 7:0) with a value below the current processor priority installs the IPI. The install is skipped when a source is pending whose pending priority is at or below the new value. Installing sets source number 2, sets the pending priority to the IPI priority, raises the output, and bounces a displaced external source.
- R5: A pending IPI that is displaced or cleared is dropped and never appears on the bounce port.
- R6: Writing a current priority (op code 0, value in bits 7:0) lower than the present one, while a source is pending with pending priority greater than or equal to the new value, clears the pending source. The pending priority becomes 0xFF, the output goes low, and the source is bounced unless it is the IPI.
- R7: Writing a current priority that is not lower, while nothing is pending, issues a resend. The resend first installs the IPI if the IPI priority is below the new current priority, then pulses `resend_req` for one cycle.
- R8: Accept (op code 2) returns the return word shown in its cycle. Afterwards bits 31:24 take the pending priority, the source number is cleared, the pending priority becomes 0xFF and the output goes low.
- R9: EOI (op code 3) loads bits 31:24 from the written value and pulses `eoi_valid` with bits 23:0 on `eoi_src`. If nothing is pending it issues a resend as in R7.
- R10: A processor operation takes precedence over a delivery in the same cycle. The delivery is held internally, `req_ready` drops, and the delivery is answered in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_op_valid | input | 1 | Processor operation strobe |
| cpu_op | input | 2 | 0 set priority, 1 set IPI priority, 2 accept, 3 EOI |
| cpu_wdata | input | 32 | Operation data |
| cpu_rdata | output | 32 | Return word: priority 31:24, pending source 23:0 |
| req_valid | input | 1 | Delivery request strobe |
| req_ready | output | 1 | Low while a delivery is held |
| req_src | input | 24 | Delivered source number |
| req_prio | input | 8 | Delivered priority |
| req_ack | output | 1 | Delivery accepted pulse |
| req_nak | output | 1 | Delivery rejected pulse |
| bounce_valid | output | 1 | Previously held source handed back |
| bounce_src | output | 24 | Number of the bounced source |
| eoi_valid | output | 1 | EOI forwarded to the source controller |
| eoi_src | output | 24 | Source number of the EOI |
| resend_req | output | 1 | Resend request to source controllers |
| irq_out | output | 1 | Interrupt line to the core |

## Verification
The arbitration rule is exercised with several delivery patterns against an occupied slot. A request equal to the pending priority is rejected, while a strictly better one displaces the holder. A request equal to the current priority is rejected, and the next better one is accepted. Together these separate the strict from the non-strict comparisons on both sides. IPI writes are tried both above and below the pending priority, and with an IPI as holder. This shows that only external holders are ever bounced. Priority narrowing, widening and EOI sequences cover the resend path with and without an IPI waiting, and a same-cycle operation and delivery shows the held request being answered one cycle late.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } cpu_op_e;
endpackage

// File: rtl/irq_req_hold.sv
// One-entry holding stage for a delivery that collides with a core operation.
module irq_req_hold #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic              stall,
  output logic              ready,
  output logic              eff_valid,
  output logic [SRC_W-1:0]  eff_src,
  output logic [PRIO_W-1:0] eff_prio
);
  logic              hold_v_q, hold_v_d, load_en;
  logic [SRC_W-1:0]  hold_src_q;
  logic [PRIO_W-1:0] hold_prio_q;

  always_comb begin
    ready     = ~hold_v_q;
    eff_valid = hold_v_q | in_valid;
    eff_src   = hold_v_q ? hold_src_q  : in_src;
    eff_prio  = hold_v_q ? hold_prio_q : in_prio;
    hold_v_d  = stall & eff_valid;
    load_en   = stall & in_valid & ~hold_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q    <= 1'b0;
      hold_src_q  <= '0;
      hold_prio_q <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      if (load_en) begin
        hold_src_q  <= in_src;
        hold_prio_q <= in_prio;
      end
    end
  end
endmodule

// File: rtl/irq_prio_cmp.sv
// Favour comparisons shared by delivery and IPI arbitration.
module irq_prio_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cmp_cppr,
  input  logic              busy,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              req_win,
  output logic              ipi_win
);
  always_comb begin
    req_win = (req_prio < cmp_cppr) && !(busy && (pend_prio <= req_prio));
    ipi_win = (ipi_prio < cmp_cppr) && !(busy && (pend_prio <= ipi_prio));
  end
endmodule

// File: rtl/irq_present_ctl.sv
module irq_present_ctl
  import irq_pres_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_op_valid,
  input  logic [1:0]              cpu_op,
  input  logic [PRIO_W+SRC_W-1:0] cpu_wdata,
  output logic [PRIO_W+SRC_W-1:0] cpu_rdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  output logic                    req_ack,
  output logic                    req_nak,
  output logic                    bounce_valid,
  output logic [SRC_W-1:0]        bounce_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req,
  output logic                    irq_out
);
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] MASKED = '1;
  localparam logic [SRC_W-1:0]  IPI_ID = SRC_W'(IPI_SRC);

  cpu_op_e op_e;
  assign op_e = cpu_op_e'(cpu_op);

  logic [PRIO_W-1:0] cppr_q, cppr_d, pp_q, pp_d, mfrr_q, mfrr_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic              irq_q, irq_d;
  logic              ack_d, nak_d, bv_d, eoi_v_d, rs_d;
  logic [SRC_W-1:0]  bsrc_d, esrc_d;
  logic              state_en;

  logic              eff_v, take;
  logic [SRC_W-1:0]  eff_src;
  logic [PRIO_W-1:0] eff_prio, eff_cppr, eff_mfrr;
  logic              busy, req_win, ipi_win, ipi_go, drop;

  irq_req_hold #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) hold_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_src(req_src), .in_prio(req_prio),
    .stall(cpu_op_valid), .ready(req_ready),
    .eff_valid(eff_v), .eff_src(eff_src), .eff_prio(eff_prio)
  );

  assign busy = (src_q != '0);
  assign take = eff_v & ~cpu_op_valid;

  always_comb begin
    eff_cppr = cppr_q;
    if (cpu_op_valid && op_e == OP_SET_CPPR) eff_cppr = cpu_wdata[PRIO_W-1:0];
    if (cpu_op_valid && op_e == OP_EOI)      eff_cppr = cpu_wdata[WORD_W-1 -: PRIO_W];
    eff_mfrr = (cpu_op_valid && op_e == OP_SET_IPI) ? cpu_wdata[PRIO_W-1:0] : mfrr_q;
  end

  irq_prio_cmp #(.PRIO_W(PRIO_W)) cmp_i (
    .cmp_cppr(eff_cppr), .busy(busy), .pend_prio(pp_q),
    .req_prio(eff_prio), .ipi_prio(eff_mfrr),
    .req_win(req_win), .ipi_win(ipi_win)
  );

  always_comb begin
    cppr_d = cppr_q; pp_d = pp_q; mfrr_d = mfrr_q; src_d = src_q; irq_d = irq_q;
    ack_d = 1'b0; nak_d = 1'b0; bv_d = 1'b0; bsrc_d = '0;
    eoi_v_d = 1'b0; esrc_d = '0; rs_d = 1'b0;
    ipi_go = 1'b0; drop = 1'b0;
    state_en = cpu_op_valid | take;
    if (cpu_op_valid) begin
      unique case (op_e)
        OP_SET_CPPR: begin
          cppr_d = eff_cppr;
          if (eff_cppr < cppr_q) begin
            drop = busy && (eff_cppr <= pp_q);
          end else if (!busy) begin
            rs_d   = 1'b1;
            ipi_go = ipi_win;
          end
        end
        OP_SET_IPI: begin
          mfrr_d = eff_mfrr;
          ipi_go = ipi_win;
        end
        OP_ACCEPT: begin
          cppr_d = pp_q;
          src_d  = '0;
          pp_d   = MASKED;
          irq_d  = 1'b0;
        end
        OP_EOI: begin
          cppr_d  = eff_cppr;
          eoi_v_d = 1'b1;
          esrc_d  = cpu_wdata[SRC_W-1:0];
          if (!busy) begin
            rs_d   = 1'b1;
            ipi_go = ipi_win;
          end
        end
        default: ;
      endcase
      if (drop) begin
        bv_d   = (src_q != IPI_ID);
        bsrc_d = (src_q != IPI_ID) ? src_q : '0;
        src_d  = '0;
        pp_d   = MASKED;
        irq_d  = 1'b0;
      end
      if (ipi_go) begin
        bv_d   = busy && (src_q != IPI_ID);
        bsrc_d = (busy && (src_q != IPI_ID)) ? src_q : '0;
        src_d  = IPI_ID;
        pp_d   = eff_mfrr;
        irq_d  = 1'b1;
      end
    end else if (take) begin
      if (req_win) begin
        bv_d   = busy && (src_q != IPI_ID);
        bsrc_d = (busy && (src_q != IPI_ID)) ? src_q : '0;
        src_d  = eff_src;
        pp_d   = eff_prio;
        irq_d  = 1'b1;
        ack_d  = 1'b1;
      end else begin
        nak_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      src_q  <= '0;
      pp_q   <= MASKED;
      mfrr_q <= MASKED;
      irq_q  <= 1'b0;
    end else if (state_en) begin
      cppr_q <= cppr_d;
      src_q  <= src_d;
      pp_q   <= pp_d;
      mfrr_q <= mfrr_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ack <= 1'b0; req_nak <= 1'b0;
      bounce_valid <= 1'b0; bounce_src <= '0;
      eoi_valid <= 1'b0; eoi_src <= '0;
      resend_req <= 1'b0;
    end else begin
      req_ack <= ack_d; req_nak <= nak_d;
      bounce_valid <= bv_d; bounce_src <= bsrc_d;
      eoi_valid <= eoi_v_d; eoi_src <= esrc_d;
      resend_req <= rs_d;
    end
  end

  assign cpu_rdata = {cppr_q, src_q};
  assign irq_out   = irq_q;
endmodule

// File: rtl/irq_present_chk.sv
module irq_present_chk #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_op_valid,
  input logic [1:0]              cpu_op,
  input logic [PRIO_W+SRC_W-1:0] cpu_wdata,
  input logic [PRIO_W+SRC_W-1:0] cpu_rdata,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_ack,
  input logic                    req_nak,
  input logic                    bounce_valid,
  input logic [SRC_W-1:0]        bounce_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    irq_out
);
  localparam int WORD_W = PRIO_W + SRC_W;

  assert_line_tracks_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (cpu_rdata[SRC_W-1:0] != '0));

  assert_ack_raises_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> irq_out);

  assert_ipi_never_bounced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bounce_valid |-> (bounce_src != SRC_W'(IPI_SRC)) && (bounce_src != '0));

  assert_ipi_install_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op_valid && cpu_op == 2'd1 && cpu_rdata[SRC_W-1:0] == '0 &&
     cpu_wdata[PRIO_W-1:0] < cpu_rdata[WORD_W-1 -: PRIO_W])
    |=> irq_out && cpu_rdata[SRC_W-1:0] == SRC_W'(IPI_SRC));

  assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op_valid && cpu_op == 2'd2) |=> !irq_out && cpu_rdata[SRC_W-1:0] == '0);

  assert_eoi_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op_valid && cpu_op == 2'd3) |=> eoi_valid &&
      eoi_src == $past(cpu_wdata[SRC_W-1:0]) &&
      cpu_rdata[WORD_W-1 -: PRIO_W] == $past(cpu_wdata[WORD_W-1 -: PRIO_W]));

  assert_collision_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op_valid && req_valid && req_ready) |=> !req_ack && !req_nak && !req_ready);
endmodule

bind irq_present_ctl irq_present_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) chk_i (.*);

// File: tb/irq_present_ctl_tb_top.sv
module irq_present_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cpu_op_valid = 1'b0;
  logic [1:0]  cpu_op = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        req_ack, req_nak, bounce_valid, eoi_valid, resend_req, irq_out;
  logic [23:0] bounce_src, eoi_src;

  irq_present_ctl dut_i (.*);

  typedef struct packed {
    logic        is_op;
    logic [1:0]  op;
    logic [31:0] wdata;
    logic [23:0] rsrc;
    logic [7:0]  rprio;
    logic [31:0] ret;
    logic        irq, ack, nak, bv;
    logic [23:0] bsrc;
    logic        rsnd, eoi;
    logic [23:0] esrc;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b1, 2'd0, 32'h0000_00FF, 24'h0,  8'h00, 32'hFF00_0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0,  1'b1, 1'b0, 24'h0},
    '{1'b0, 2'd0, 32'h0,         24'h10, 8'h05, 32'hFF00_0010, 1'b1, 1'b1, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b0, 2'd0, 32'h0,         24'h11, 8'h05, 32'hFF00_0010, 1'b1, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b0, 2'd0, 32'h0,         24'h12, 8'h03, 32'hFF00_0012, 1'b1, 1'b1, 1'b0, 1'b1, 24'h10, 1'b0, 1'b0, 24'h0},
    '{1'b1, 2'd1, 32'h0000_0004, 24'h0,  8'h00, 32'hFF00_0012, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b1, 2'd1, 32'h0000_0001, 24'h0,  8'h00, 32'hFF00_0002, 1'b1, 1'b0, 1'b0, 1'b1, 24'h12, 1'b0, 1'b0, 24'h0},
    '{1'b0, 2'd0, 32'h0,         24'h13, 8'h00, 32'hFF00_0013, 1'b1, 1'b1, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b1, 2'd2, 32'h0,         24'h0,  8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b1, 2'd3, 32'hFF00_0013, 24'h0,  8'h00, 32'hFF00_0002, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0,  1'b1, 1'b1, 24'h13},
    '{1'b1, 2'd0, 32'h0000_0001, 24'h0,  8'h00, 32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b0, 2'd0, 32'h0,         24'h20, 8'h01, 32'h0100_0000, 1'b0, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b0, 2'd0, 32'h0,         24'h20, 8'h00, 32'h0100_0020, 1'b1, 1'b1, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0},
    '{1'b1, 2'd0, 32'h0000_0000, 24'h0,  8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 24'h20, 1'b0, 1'b0, 24'h0},
    '{1'b1, 2'd0, 32'h0000_0005, 24'h0,  8'h00, 32'h0500_0002, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0,  1'b1, 1'b0, 24'h0},
    '{1'b1, 2'd2, 32'h0,         24'h0,  8'h00, 32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 24'h0}
  };

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_op_valid = 1'b0; req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    ck("R1 reset return word", cpu_rdata, 32'h0);
    ck("R1 reset line", {31'b0, irq_out}, 32'h0);
    ck("R1 reset ready", {31'b0, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_op_valid = 1'b1; cpu_op = 2'd2; cpu_wdata = '0;
    @(negedge clk); idle();
    ck("R1 accept after reset shows pending prio FF", cpu_rdata, 32'hFF00_0000);

    for (int i = 0; i < 15; i++) begin
      if (VEC[i].is_op) begin
        cpu_op_valid = 1'b1; cpu_op = VEC[i].op; cpu_wdata = VEC[i].wdata;
      end else begin
        req_valid = 1'b1; req_src = VEC[i].rsrc; req_prio = VEC[i].rprio;
      end
      @(negedge clk); idle();
      ck($sformatf("R3 R4 R6 R7 R8 R9 return word v%0d", i), cpu_rdata, VEC[i].ret);
      ck($sformatf("R3 line v%0d", i), {31'b0, irq_out}, {31'b0, VEC[i].irq});
      ck($sformatf("R2 R3 ack/nak v%0d", i), {30'b0, req_ack, req_nak}, {30'b0, VEC[i].ack, VEC[i].nak});
      ck($sformatf("R3 R4 R5 R6 bounce v%0d", i), {7'b0, bounce_valid, bounce_src}, {7'b0, VEC[i].bv, VEC[i].bsrc});
      ck($sformatf("R7 R9 resend v%0d", i), {31'b0, resend_req}, {31'b0, VEC[i].rsnd});
      ck($sformatf("R9 eoi v%0d", i), {7'b0, eoi_valid, eoi_src}, {7'b0, VEC[i].eoi, VEC[i].esrc});
    end

    // R10: operation and delivery collide; state now priority 01, IPI prio 01, nothing pending
    ck("R8 word before collision", cpu_rdata, 32'h0100_0000);
    cpu_op_valid = 1'b1; cpu_op = 2'd1; cpu_wdata = 32'h0000_00FF;
    req_valid = 1'b1; req_src = 24'h30; req_prio = 8'h00;
    @(negedge clk); idle();
    ck("R10 no answer in collision cycle", {30'b0, req_ack, req_nak}, 32'h0);
    ck("R10 ready low while held", {31'b0, req_ready}, 32'h0);
    ck("R4 IPI prio FF not installed", cpu_rdata, 32'h0100_0000);
    @(negedge clk);
    ck("R10 held delivery acked next cycle", {30'b0, req_ack, req_nak}, 32'h2);
    ck("R10 held delivery latched", cpu_rdata, 32'h0100_0030);
    ck("R10 ready restored", {31'b0, req_ready}, 32'h1);

    // R8: accept returns the word shown in its own cycle
    ck("R8 returned word", cpu_rdata, 32'h0100_0030);
    cpu_op_valid = 1'b1; cpu_op = 2'd2;
    @(negedge clk); idle();
    ck("R8 accept loads pending prio", cpu_rdata, 32'h0000_0000);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule